// File: doc/BRIEF.md
# I2C Master Transfer Engine

This block runs master-side transfers on a two-wire I2C bus. An external timing source supplies a strobe at four times the bit rate. From that strobe the engine produces the SCL waveform and places and samples SDA. A command selects the target address in 7-bit or 10-bit form, the direction, and the word length of 1 to `WORD_W` bits. The engine then issues a START, sends the address bytes, checks each acknowledge and parks the bus with SCL held low.

While the bus is parked, the client can do one of four things. It can hand over a transmit word with a valid/ready handshake. It can request a receive word and say whether to acknowledge it. It can issue a repeated START with a new command, or ask for a STOP. Both bus lines are open-drain: an output of 1 pulls the line low, and 0 releases it.

If another master wins the line during a bit the engine meant to leave high, the engine releases both lines at once, raises a sticky arbitration flag and drops back to idle without a STOP. A sticky flag also reports an address or data byte that was not acknowledged.

Top module: `i2c_master_engine`

## Requirements
- R1: While `rstN` is low, and in the cycle after it is sampled low, `sdaOe`, `sclOe`, `busy`, `nackFlag` and `arbLost` are all 0, so both lines are released.
- R2: A START, including a repeated START, is a fall of SDA while SCL is released, and SCL is then pulled low before the first bit.
- R3: Apart from a START or a STOP, `sdaOe` changes only while `sclOe` is 1 (SCL held low).
- R4: In 7-bit mode the address byte is `cmdAddr[6:0]` followed by the R/W bit (`cmdRead`, 1 = read), sent MSB first with one SCL pulse per bit.
- R5: In 10-bit mode the bytes are `11110`,`cmdAddr[9:8]`,`0` and then `cmdAddr[7:0]`, each with its own acknowledge. For a read, a repeated START follows with `11110`,`cmdAddr[9:8]`,`1`.
- R6: A data word has `cmdBitCount` bits, where 0 selects `WORD_W`. It is taken from the low bits of `txData` and sent MSB first.
- R7: A read word is shifted in MSB first. At the end of its acknowledge bit it appears in the low bits of `rxData`, with a one-cycle `rxValid`. During that bit the engine pulls SDA low when `rdNack` was 0 and leaves it released when `rdNack` was 1.
- R8: A released SDA sampled in the acknowledge bit of a byte the engine sent sets `nackFlag`. The flag stays set until the next START is accepted.
- R9: If the engine releases SDA for a 1 but samples the line low, it releases SDA and SCL in that same clock edge, sets `arbLost`, drops `busy` and generates no STOP.
- R10: A STOP is a rise of SDA while SCL is released. After it the engine is idle with both lines released.
- R11: Any number of words may follow one START. Between words SCL stays held low until the next word, START or STOP is requested.
- R12: `txReady` is high only while the bus is parked in a write transfer. A word is consumed in the cycle where `txValid` and `txReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Quarter-bit strobe from the timing source |
| cmdStart | input | 1 | Request a START (or repeated START) with the command fields |
| cmdStop | input | 1 | Request a STOP from the parked state |
| cmdRead | input | 1 | Direction, 1 = read |
| cmdTenBit | input | 1 | 1 = 10-bit address |
| cmdAddr | input | 10 | Target address (7-bit mode uses bits 6:0) |
| cmdBitCount | input | 3 | Data word length, 0 = WORD_W |
| cmdReady | output | 1 | Engine idle or parked; commands accepted |
| txData | input | WORD_W | Transmit word, low bits used |
| txValid | input | 1 | Transmit word valid |
| txReady | output | 1 | Transmit word can be taken |
| rdReq | input | 1 | Start a receive word when parked |
| rdNack | input | 1 | Answer the requested word with NACK |
| rxData | output | WORD_W | Last received word |
| rxValid | output | 1 | One-cycle pulse when rxData is updated |
| sdaIn | input | 1 | Sampled SDA line |
| sdaOe | output | 1 | 1 pulls SDA low |
| sclOe | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Engine not idle |
| nackFlag | output | 1 | Sticky NACK received |
| arbLost | output | 1 | Sticky arbitration lost |

## Verification
Each bus action waits for one `tick`. SDA is set on the first tick after SCL is pulled low. SCL is released on the next tick, and SDA is sampled on the tick after that, so a bit spans four ticks. The arbitration flag, the NACK flag and the line release are updated on the sampling tick. `rxData` and `rxValid` change on the tick that pulls SCL low at the end of the acknowledge bit. The bench does not count fixed delays from a command. It follows the SCL and SDA edges it sees at falling clock edges: it reads each bit when SCL rises, and it checks flags and received words only after the SCL fall that closes the relevant bit. For arbitration loss it allows a two-tick window after SCL rises.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSA,   // repeated start: release SDA under low SCL
    ST_RSB,   // repeated start: release SCL
    ST_SHI,   // both high, next edge pulls SDA (start)
    ST_SLO,   // SDA low, next edge pulls SCL
    ST_XFER,  // data or address bits
    ST_ACK,   // acknowledge bit
    ST_HOLD,  // parked with SCL low
    ST_SPA,   // stop: pull SDA
    ST_SPB,   // stop: release SCL
    ST_SPC    // stop: release SDA
  } state_t;

  typedef struct packed {
    logic load;
    logic shiftTx;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] loadVal,
  input  logic [CNT_W-1:0]  loadLen,
  input  logic              sdaIn,
  output logic              txBit,
  output logic              lastBit,
  output logic [WORD_W-1:0] rxWord
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [CNT_W-1:0]  bitsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      bitsLeft <= '0;
    end else begin
      if (strobe.load) begin
        // left-align the word so the top bit goes out first
        txShift  <= loadVal << (CNT_W'(WORD_W) - loadLen);
        bitsLeft <= loadLen;
        rxShift  <= '0;
      end else begin
        if (strobe.shiftTx) begin
          txShift  <= txShift << 1;
          bitsLeft <= bitsLeft - CNT_W'(1);
        end
        if (strobe.capture) begin
          rxShift <= {rxShift[WORD_W-2:0], sdaIn};
        end
      end
    end
  end

  assign txBit   = txShift[WORD_W-1];
  assign lastBit = (bitsLeft == CNT_W'(1));
  assign rxWord  = rxShift;

endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int BC_W  = $clog2(WORD_W),
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdRead,
  input  logic              cmdTenBit,
  input  logic [9:0]        cmdAddr,
  input  logic [BC_W-1:0]   cmdBitCount,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  input  logic              rdReq,
  input  logic              rdNack,
  input  logic              sdaIn,
  input  logic              txBit,
  input  logic              lastBit,
  input  logic [WORD_W-1:0] rxWord,
  output dpStrobe_t         strobe,
  output logic [WORD_W-1:0] loadVal,
  output logic [CNT_W-1:0]  loadLen,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              cmdReady,
  output logic              txReady,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic              nackFlag,
  output logic              arbLost,
  output state_t            state
);

  logic [1:0]      phase;
  logic            sdaOeR, sclOeR;
  logic            curRd, curTen;
  logic [9:0]      curAddr;
  logic [BC_W-1:0] curBc;
  logic [1:0]      addrIdx;
  logic            inAddr, wordRx, ackNack, gotAck;
  logic            nackF, arbF, rxValidR;
  logic [WORD_W-1:0] rxDataR;

  logic startTake, stopTake, txTake, rdTake, toAddr2, endBit;
  logic [CNT_W-1:0] wordLen;

  function automatic logic [7:0] addrByte(input logic [1:0] idx);
    if (!curTen)          return {curAddr[6:0], curRd};
    else if (idx == 2'd1) return curAddr[7:0];
    else                  return {5'b11110, curAddr[9:8], (idx == 2'd2)};
  endfunction

  assign cmdReady  = (state == ST_IDLE) || (state == ST_HOLD);
  assign startTake = cmdStart && cmdReady;
  assign stopTake  = cmdStop && (state == ST_HOLD);
  assign txReady   = (state == ST_HOLD) && !curRd && !cmdStart && !cmdStop;
  assign txTake    = txValid && txReady;
  assign rdTake    = rdReq && (state == ST_HOLD) && curRd && !cmdStart && !cmdStop;
  assign endBit    = tick && (phase == 2'd3);
  assign toAddr2   = (state == ST_ACK) && endBit && inAddr && gotAck && curTen
                     && (addrIdx == 2'd0);
  assign wordLen   = (curBc == '0) ? CNT_W'(WORD_W) : CNT_W'(curBc);

  always_comb begin
    strobe  = '0;
    loadVal = '0;
    loadLen = '0;
    if ((state == ST_SLO) && tick) begin
      strobe.load = 1'b1;
      loadVal     = WORD_W'(addrByte(addrIdx));
      loadLen     = CNT_W'(8);
    end else if (toAddr2) begin
      strobe.load = 1'b1;
      loadVal     = WORD_W'(addrByte(2'd1));
      loadLen     = CNT_W'(8);
    end else if (txTake) begin
      strobe.load = 1'b1;
      loadVal     = txData;
      loadLen     = wordLen;
    end else if (rdTake) begin
      strobe.load = 1'b1;
      loadLen     = wordLen;
    end
    if ((state == ST_XFER) && tick) begin
      strobe.capture = (phase == 2'd2);
      strobe.shiftTx = (phase == 2'd3) && !lastBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      sdaOeR   <= 1'b0;
      sclOeR   <= 1'b0;
      curRd    <= 1'b0;
      curTen   <= 1'b0;
      curAddr  <= '0;
      curBc    <= '0;
      addrIdx  <= '0;
      inAddr   <= 1'b0;
      wordRx   <= 1'b0;
      ackNack  <= 1'b0;
      gotAck   <= 1'b0;
      nackF    <= 1'b0;
      arbF     <= 1'b0;
      rxValidR <= 1'b0;
      rxDataR  <= '0;
    end else begin
      rxValidR <= 1'b0;
      if (startTake) begin
        curRd   <= cmdRead;
        curTen  <= cmdTenBit;
        curAddr <= cmdAddr;
        curBc   <= cmdBitCount;
        addrIdx <= 2'd0;
        nackF   <= 1'b0;
        arbF    <= 1'b0;
        state   <= (state == ST_IDLE) ? ST_SHI : ST_RSA;
      end else if (stopTake) begin
        state <= ST_SPA;
      end else if (txTake || rdTake) begin
        state   <= ST_XFER;
        phase   <= 2'd0;
        inAddr  <= 1'b0;
        wordRx  <= rdTake;
        ackNack <= rdNack;
      end else if (tick) begin
        case (state)
          ST_RSA: begin sdaOeR <= 1'b0; state <= ST_RSB; end
          ST_RSB: begin sclOeR <= 1'b0; state <= ST_SHI; end
          ST_SHI: begin sdaOeR <= 1'b1; state <= ST_SLO; end
          ST_SLO: begin
            sclOeR <= 1'b1;
            state  <= ST_XFER;
            phase  <= 2'd0;
            inAddr <= 1'b1;
            wordRx <= 1'b0;
          end
          ST_XFER: begin
            phase <= phase + 2'd1;
            case (phase)
              2'd0: sdaOeR <= wordRx ? 1'b0 : !txBit;
              2'd1: sclOeR <= 1'b0;
              2'd2: if (!wordRx && txBit && !sdaIn) begin
                arbF   <= 1'b1;
                sdaOeR <= 1'b0;
                sclOeR <= 1'b0;
                state  <= ST_IDLE;
              end
              default: begin
                sclOeR <= 1'b1;
                if (lastBit) state <= ST_ACK;
              end
            endcase
          end
          ST_ACK: begin
            phase <= phase + 2'd1;
            case (phase)
              2'd0: sdaOeR <= wordRx ? !ackNack : 1'b0;
              2'd1: sclOeR <= 1'b0;
              2'd2: begin
                gotAck <= !sdaIn;
                if (!wordRx && sdaIn) nackF <= 1'b1;
              end
              default: begin
                sclOeR <= 1'b1;
                if (wordRx) begin
                  rxValidR <= 1'b1;
                  rxDataR  <= rxWord;
                end
                if (toAddr2) begin
                  addrIdx <= 2'd1;
                  state   <= ST_XFER;
                end else if (inAddr && gotAck && curTen && curRd && addrIdx == 2'd1) begin
                  addrIdx <= 2'd2;
                  state   <= ST_RSA;
                end else begin
                  state <= ST_HOLD;
                end
              end
            endcase
          end
          ST_SPA: begin sdaOeR <= 1'b1; state <= ST_SPB; end
          ST_SPB: begin sclOeR <= 1'b0; state <= ST_SPC; end
          ST_SPC: begin sdaOeR <= 1'b0; state <= ST_IDLE; end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe    = sdaOeR;
  assign sclOe    = sclOeR;
  assign rxValid  = rxValidR;
  assign rxData   = rxDataR;
  assign nackFlag = nackF;
  assign arbLost  = arbF;

endmodule

// File: rtl/i2c_master_engine.sv
module i2c_master_engine
  import i2cm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdRead,
  input  logic              cmdTenBit,
  input  logic [9:0]        cmdAddr,
  input  logic [2:0]        cmdBitCount,
  output logic              cmdReady,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              rdReq,
  input  logic              rdNack,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              busy,
  output logic              nackFlag,
  output logic              arbLost
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  dpStrobe_t         dpStrobe;
  logic [WORD_W-1:0] dpLoadVal;
  logic [CNT_W-1:0]  dpLoadLen;
  logic              dpTxBit, dpLastBit;
  logic [WORD_W-1:0] dpRxWord;
  state_t            ctlState;

  i2cm_control #(.WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdRead(cmdRead),
    .cmdTenBit(cmdTenBit), .cmdAddr(cmdAddr), .cmdBitCount(cmdBitCount),
    .txData(txData), .txValid(txValid), .rdReq(rdReq), .rdNack(rdNack),
    .sdaIn(sdaIn), .txBit(dpTxBit), .lastBit(dpLastBit), .rxWord(dpRxWord),
    .strobe(dpStrobe), .loadVal(dpLoadVal), .loadLen(dpLoadLen),
    .sdaOe(sdaOe), .sclOe(sclOe), .cmdReady(cmdReady), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .nackFlag(nackFlag),
    .arbLost(arbLost), .state(ctlState)
  );

  i2cm_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(dpStrobe), .loadVal(dpLoadVal),
    .loadLen(dpLoadLen), .sdaIn(sdaIn), .txBit(dpTxBit),
    .lastBit(dpLastBit), .rxWord(dpRxWord)
  );

  assign busy = (ctlState != ST_IDLE);

endmodule

// File: rtl/i2c_master_engine_chk.sv
module i2c_master_engine_chk
  import i2cm_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   sdaOe,
  input logic   sclOe,
  input logic   busy,
  input logic   cmdReady,
  input logic   cmdStart,
  input logic   txReady,
  input logic   nackFlag,
  input logic   arbLost,
  input state_t st
);

  AST_RESET_RELEASE: assert property (@(posedge clk)
    !rstN |=> (!sdaOe && !sclOe && !busy && !nackFlag && !arbLost)); // R1

  AST_START_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && !sclOe) |-> (st == ST_SLO)); // R2

  AST_SDA_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe) && (sdaOe != $past(sdaOe)))
      |-> ($past(st) == ST_SHI || $past(st) == ST_SPC)); // R3

  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(nackFlag) && !$past(cmdStart && cmdReady)) |-> nackFlag); // R8

  AST_ARB_WITHDRAW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> (!sdaOe && !sclOe && !busy)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> (!sdaOe && !sclOe)); // R10

  AST_TXREADY_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (busy && sclOe && cmdReady)); // R12

endmodule

bind i2c_master_engine i2c_master_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclOe(sclOe), .busy(busy),
  .cmdReady(cmdReady), .cmdStart(cmdStart), .txReady(txReady),
  .nackFlag(nackFlag), .arbLost(arbLost), .st(ctlState)
);

// File: tb/tb_i2c_master_engine.sv
`timescale 1ns/1ps
module tb_i2c_master_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] tickCnt = 2'd0;
  logic tick;
  logic cmdStart = 0, cmdStop = 0, cmdRead = 0, cmdTenBit = 0;
  logic [9:0] cmdAddr = '0;
  logic [2:0] cmdBitCount = '0;
  logic cmdReady;
  logic [7:0] txData = '0;
  logic txValid = 0, txReady;
  logic rdReq = 0, rdNack = 0;
  logic [7:0] rxData;
  logic rxValid;
  logic sdaIn, sdaOe, sclOe, busy, nackFlag, arbLost;
  logic slvLow = 1'b0;
  logic sdaLine, sclLine;
  int nChecks = 0, nFail = 0, rxCount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tickCnt <= tickCnt + 2'd1;
  always @(posedge clk) if (rxValid) rxCount <= rxCount + 1;
  assign tick    = (tickCnt == 2'd3);
  assign sdaLine = !(sdaOe || slvLow);
  assign sclLine = !sclOe;
  assign sdaIn   = sdaLine;

  i2c_master_engine dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdRead(cmdRead), .cmdTenBit(cmdTenBit), .cmdAddr(cmdAddr),
    .cmdBitCount(cmdBitCount), .cmdReady(cmdReady), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rdReq(rdReq), .rdNack(rdNack),
    .rxData(rxData), .rxValid(rxValid), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .sclOe(sclOe), .busy(busy), .nackFlag(nackFlag), .arbLost(arbLost)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issueStart(input logic rd, input logic ten, input logic [9:0] a,
                            input logic [2:0] bc);
    @(negedge clk);
    for (int i = 0; i < 400 && !cmdReady; i++) @(negedge clk);
    cmdRead = rd; cmdTenBit = ten; cmdAddr = a; cmdBitCount = bc; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
  endtask

  task automatic issueStop();
    @(negedge clk);
    for (int i = 0; i < 400 && !(cmdReady && busy); i++) @(negedge clk);
    cmdStop = 1;
    @(negedge clk);
    cmdStop = 0;
  endtask

  task automatic sendWord(input logic [7:0] d, input string tag);
    int n = 0;
    @(negedge clk);
    while (n < 400 && !txReady) begin @(negedge clk); n++; end
    check({tag, " txReady while parked"}, txReady, 1);
    txData = d; txValid = 1;
    @(negedge clk);
    txValid = 0;
  endtask

  task automatic readReq(input logic nk);
    @(negedge clk);
    for (int i = 0; i < 400 && !(cmdReady && busy); i++) @(negedge clk);
    rdNack = nk; rdReq = 1;
    @(negedge clk);
    rdReq = 0;
  endtask

  task automatic waitStart(input string tag);
    logic pS, pC;
    bit seen = 0;
    pS = sdaLine; pC = sclLine;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (pS && !sdaLine && pC && sclLine) seen = 1;
      pS = sdaLine; pC = sclLine;
    end
    check({tag, " start condition"}, seen, 1);
    for (int i = 0; i < 400 && sclLine; i++) @(negedge clk);
  endtask

  task automatic waitStop(input string tag);
    logic pS, pC;
    bit seen = 0;
    pS = sdaLine; pC = sclLine;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (!pS && sdaLine && pC && sclLine) seen = 1;
      pS = sdaLine; pC = sclLine;
    end
    check({tag, " stop condition"}, seen, 1);
  endtask

  task automatic busBit(input logic slv, output logic seen);
    int n = 0;
    slvLow = slv;
    while (n < 400 && !sclLine) begin @(negedge clk); n++; end
    seen = sdaLine;
    while (n < 800 && sclLine) begin @(negedge clk); n++; end
    slvLow = 0;
    if (n >= 800) check("bus bit timeout", 0, 1);
  endtask

  // slvBits: value the far side places on SDA (1 = released)
  task automatic busWord(input int n, input logic [7:0] slvBits, output logic [7:0] seen);
    seen = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic b;
      busBit(!slvBits[i], b);
      seen = {seen[6:0], b};
    end
  endtask

  task automatic testReset();
    check("R1 sdaOe after reset", sdaOe, 0);
    check("R1 sclOe after reset", sclOe, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 flags after reset", {nackFlag, arbLost}, 0);
    check("R12 txReady idle", txReady, 0);
  endtask

  task automatic testWrite7();
    logic [7:0] w; logic a;
    issueStart(0, 0, 10'h05A, 3'd0);
    waitStart("R2 write7");
    busWord(8, 8'hFF, w); check("R4 address byte", w, 8'hB4);
    busBit(1, a);
    sendWord(8'hC3, "R12");
    busWord(8, 8'hFF, w); check("R6 full word", w, 8'hC3);
    busBit(1, a);
    @(negedge clk);
    check("R11 SCL held low between words", sclOe, 1);
    sendWord(8'h3C, "R11");
    busWord(8, 8'hFF, w); check("R11 second word", w, 8'h3C);
    busBit(1, a);
    check("R8 no nack on acked bytes", nackFlag, 0);
    issueStop();
    waitStop("R10 write7");
    check("R10 idle released", {busy, sdaOe, sclOe}, 0);
  endtask

  task automatic testShortWords();
    logic [7:0] w; logic a;
    issueStart(0, 0, 10'h021, 3'd5);
    waitStart("R2 short");
    busWord(8, 8'hFF, w); check("R4 address 0x21", w, 8'h42);
    busBit(1, a);
    sendWord(8'h16, "R12");
    busWord(5, 8'hFF, w); check("R6 five-bit word", w, 8'h16);
    busBit(1, a);
    issueStart(0, 0, 10'h021, 3'd1);
    waitStart("R2 repeated start");
    busWord(8, 8'hFF, w); check("R4 address after repeat", w, 8'h42);
    busBit(1, a);
    sendWord(8'h01, "R12");
    busWord(1, 8'hFF, w); check("R6 one-bit word", w, 8'h01);
    busBit(1, a);
    issueStop();
    waitStop("R10 short");
  endtask

  task automatic testRead7();
    logic [7:0] w; logic a; int c0;
    issueStart(1, 0, 10'h033, 3'd0);
    waitStart("R2 read7");
    busWord(8, 8'hFF, w); check("R4 read address byte", w, 8'h67);
    busBit(1, a);
    repeat (2) @(negedge clk);
    check("R12 no txReady in read", txReady, 0);
    c0 = rxCount;
    readReq(0);
    busWord(8, 8'hA5, w);
    busBit(0, a); check("R7 master ack low", a, 0);
    repeat (2) @(negedge clk);
    check("R7 rxData first", rxData, 8'hA5);
    check("R7 rxValid count", rxCount - c0, 1);
    readReq(1);
    busWord(8, 8'h5B, w);
    busBit(0, a); check("R7 master nack released", a, 1);
    repeat (2) @(negedge clk);
    check("R7 rxData second", rxData, 8'h5B);
    issueStop();
    waitStop("R10 read7");
  endtask

  task automatic testWrite10();
    logic [7:0] w; logic a;
    issueStart(0, 1, 10'h2A7, 3'd0);
    waitStart("R2 write10");
    busWord(8, 8'hFF, w); check("R5 first 10-bit byte", w, 8'hF4);
    busBit(1, a);
    busWord(8, 8'hFF, w); check("R5 second 10-bit byte", w, 8'hA7);
    busBit(1, a);
    sendWord(8'h81, "R12");
    busWord(8, 8'hFF, w); check("R6 word after 10-bit", w, 8'h81);
    busBit(1, a);
    issueStop();
    waitStop("R10 write10");
  endtask

  task automatic testRead10();
    logic [7:0] w; logic a;
    issueStart(1, 1, 10'h19C, 3'd0);
    waitStart("R2 read10");
    busWord(8, 8'hFF, w); check("R5 read first byte", w, 8'hF2);
    busBit(1, a);
    busWord(8, 8'hFF, w); check("R5 read second byte", w, 8'h9C);
    busBit(1, a);
    waitStart("R5 auto repeated start");
    busWord(8, 8'hFF, w); check("R5 read third byte", w, 8'hF3);
    busBit(1, a);
    readReq(1);
    busWord(8, 8'h6E, w);
    busBit(0, a);
    repeat (2) @(negedge clk);
    check("R7 rxData 10-bit read", rxData, 8'h6E);
    issueStop();
    waitStop("R10 read10");
  endtask

  task automatic testNack();
    logic [7:0] w; logic a;
    issueStart(0, 0, 10'h010, 3'd0);
    waitStart("R2 nack");
    busWord(8, 8'hFF, w);
    busBit(0, a);
    @(negedge clk);
    check("R8 nack flag set", nackFlag, 1);
    issueStop();
    waitStop("R10 nack");
    check("R8 nack flag kept after stop", nackFlag, 1);
    issueStart(0, 0, 10'h010, 3'd0);
    check("R8 nack flag cleared by start", nackFlag, 0);
    waitStart("R2 after nack");
    busWord(8, 8'hFF, w);
    busBit(1, a);
    issueStop();
    waitStop("R10 after nack");
  endtask

  task automatic testArb();
    logic [7:0] w; logic a;
    issueStart(0, 0, 10'h07F, 3'd0);
    waitStart("R2 arb");
    slvLow = 1;
    for (int i = 0; i < 400 && !sclLine; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R9 arbLost set", arbLost, 1);
    check("R9 lines released", {sdaOe, sclOe}, 0);
    check("R9 busy dropped", busy, 0);
    slvLow = 0;
    repeat (40) @(negedge clk);
    check("R9 no stop driven", {sdaOe, sclOe, busy}, 0);
    issueStart(0, 0, 10'h07F, 3'd0);
    check("R9 arbLost cleared by start", arbLost, 0);
    waitStart("R2 after arb");
    busWord(8, 8'hFF, w); check("R4 address 0x7F", w, 8'hFE);
    busBit(1, a);
    issueStop();
    waitStop("R10 after arb");
  endtask

  task automatic testMidReset();
    logic b;
    issueStart(0, 0, 10'h055, 3'd0);
    waitStart("R2 mid reset");
    busBit(0, b);
    busBit(0, b);
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check("R1 lines released in reset", {sdaOe, sclOe}, 0);
    check("R1 idle in reset", {busy, nackFlag, arbLost}, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 ready after reset", cmdReady, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWrite7();
    testShortWords();
    testRead7();
    testWrite10();
    testRead10();
    testNack();
    testArb();
    testMidReset();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule